// File: doc/BRIEF.md
# Bridge Command Packet Receiver

This block sits behind the bulk OUT endpoint of a USB-to-SPI bridge. It takes host packets one byte per cycle, with a valid strobe and a marker on the final byte of each packet. It decodes each packet and rebuilds a write transfer that may span several packets. The write bytes go into a buffer RAM through a plain write port, at their offset within the transfer. When the last expected byte has arrived, the block raises one pulse that lets the SPI engine start. The engine reads the transfer lengths from the `wr_len` and `rd_len` outputs.

Every packet opens with a 16-bit little-endian identifier. A start packet adds a write count and a read count, each 16-bit little-endian, followed by write payload. A continuation packet adds a 16-bit index that must equal the number of write bytes already taken, followed by more payload. Two short commands ask for the configuration or for a replay of the response. Each framing or limit fault stores its own 16-bit status code, abandons the transfer and asks the response side to answer at once.

The control path is a five-state machine. The states are `RX_ID_LO` (identifier low byte), `RX_ID_HI` (identifier high byte and dispatch), `RX_HEADER` (count or index fields), `RX_PAYLOAD` (write data) and `RX_DISCARD` (skip to the end of the packet). The transitions are:
- `RX_ID_LO`→`RX_ID_HI` on any byte that is not the last of its packet.
- `RX_ID_HI`→`RX_HEADER` for an accepted start or continuation packet.
- `RX_ID_HI`→`RX_DISCARD` after a short command or a fault, when more bytes follow.
- `RX_HEADER`→`RX_PAYLOAD` when the header is valid and payload follows.
- Any state→`RX_DISCARD` on a fault in the middle of a packet.
- Any state→`RX_ID_LO` on the last byte of a packet.

A separate `busy` flag records that a transfer is waiting for further continuation packets.

Top module: `brx_cmd_rx`

## Requirements
- R1: The first two bytes of a packet form its identifier, low byte first. The block acts on the values 0 (configuration query), 2 (transfer start), 3 (write continuation) and 4 (response replay), and on all 16 bits of the identifier.
- R2: A start packet carries the write count in bytes 2–3 and the read count in bytes 4–5, both low byte first. When the header is accepted, `wr_len` and `rd_len` take the new lengths. Otherwise they hold their old values.
- R3: Each accepted payload byte is written to the buffer at its offset within the transfer, counting across the start packet and all continuation packets. The write appears on `wbuf_we`/`wbuf_addr`/`wbuf_data` in the cycle after the byte is sampled.
- R4: Bytes 2–3 of a continuation packet (low byte first) hold an index. If the index differs from the number of write bytes already taken, the status becomes 0x0006.
- R5: A payload byte beyond the write count sets status 0x0007 and is not written. Bytes written before it stay written.
- R6: The status becomes 0x0008 in any of these cases:
  - a continuation packet arrives while no transfer is waiting;
  - a configuration query or a replay request arrives while a transfer is waiting;
  - the packet carries any other identifier;
  - the packet ends before its identifier and header are complete.
- R7: A write count above `MAX_WR` gives status 0x0003. An effective read length above `MAX_RD` gives status 0x0004.
- R8: A read count of 0xFFFF selects full duplex, with the read length equal to the write count. If `duplex_ok` is low, this gives status 0x0009 instead.
- R9: If `bridge_en` is low when a start header completes, the status is 0x0005. Header faults are ranked in this order: 0x0005, then 0x0003, then 0x0009, then 0x0004.
- R10: A start identifier clears the status to 0x0000. Otherwise the status changes only when a fault occurs.
- R11: `xfer_go` pulses for one cycle after the last byte of a packet that brings the byte total to the write count, with status 0x0000. A start packet with a write count of zero and no payload also raises it.
- R12: Every fault raises `rsp_req` for one cycle, in the same cycle the status changes. It also abandons the transfer and ignores the rest of that packet. At most one of `xfer_go`, `cfg_req` and `rsp_req` is high in any cycle.
- R13: A configuration query while no transfer is waiting pulses `cfg_req`, and a replay request pulses `rsp_req`. Neither changes the status, and any further bytes of that packet are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet byte is present |
| in_byte | input | 8 | Packet byte |
| in_last | input | 1 | The byte is the last of its packet |
| bridge_en | input | 1 | The bridge is enabled by both sides |
| duplex_ok | input | 1 | Full duplex is supported |
| wbuf_we | output | 1 | Buffer write strobe |
| wbuf_addr | output | AW | Buffer write offset |
| wbuf_data | output | 8 | Buffer write data |
| wr_len | output | 16 | Accepted write length |
| rd_len | output | 16 | Accepted read length |
| status | output | 16 | Status code of the current transfer |
| xfer_go | output | 1 | Pulse: write data complete, SPI may start |
| cfg_req | output | 1 | Pulse: configuration response wanted |
| rsp_req | output | 1 | Pulse: response wanted (fault or replay) |

## Verification
The hardest cases to reach are the faults that arise within a multi-packet transfer: a continuation index that is off by a few bytes, an extra byte after the final one, and a short command that arrives while a transfer is waiting. A correctly behaving host never produces any of these. The bench therefore builds each packet byte by byte, with the header fields written explicitly. This lets it start a valid transfer, and then send a continuation packet with a wrong index, too much payload, or a foreign identifier at the chosen moment. A sweep over every write length of a small configuration, split across packets in two ways and sent with and without idle gaps, covers the reassembly offsets and the end-of-transfer pulse.

// File: rtl/brx_pkg.sv
package brx_pkg;

    // status codes reported to the response side
    localparam logic [15:0] CODE_OK         = 16'h0000;
    localparam logic [15:0] CODE_WR_LIMIT   = 16'h0003;
    localparam logic [15:0] CODE_RD_LIMIT   = 16'h0004;
    localparam logic [15:0] CODE_OFF        = 16'h0005;
    localparam logic [15:0] CODE_BAD_INDEX  = 16'h0006;
    localparam logic [15:0] CODE_OVERFLOW   = 16'h0007;
    localparam logic [15:0] CODE_UNEXPECTED = 16'h0008;
    localparam logic [15:0] CODE_NO_DUPLEX  = 16'h0009;

    // host packet identifiers
    localparam logic [15:0] PID_CONFIG = 16'd0;
    localparam logic [15:0] PID_START  = 16'd2;
    localparam logic [15:0] PID_MORE   = 16'd3;
    localparam logic [15:0] PID_REPLAY = 16'd4;

    // read count value that selects full duplex
    localparam logic [15:0] RD_DUPLEX = 16'hFFFF;

    typedef enum logic [2:0] {
        RX_ID_LO,
        RX_ID_HI,
        RX_HEADER,
        RX_PAYLOAD,
        RX_DISCARD
    } rx_state_e;

    typedef enum logic {
        HK_START,
        HK_MORE
    } hdr_kind_e;

endpackage

// File: rtl/brx_word_join.sv
// Joins a little-endian 16-bit field: the low byte is held, and the high
// byte is taken straight from the input when it arrives.
module brx_word_join #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_en,
    input  logic [BW-1:0]   byte_in,
    output logic [2*BW-1:0] word
);
    logic [BW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (lo_en) lo_q <= byte_in;
    end

    assign word = {byte_in, lo_q};
endmodule

// File: rtl/brx_hdr_check.sv
// Validates a start header and ranks the faults in a fixed order.
module brx_hdr_check
    import brx_pkg::*;
#(
    parameter int MAX_WR = 298,
    parameter int MAX_RD = 298
) (
    input  logic        bridge_en,
    input  logic        duplex_ok,
    input  logic [15:0] wr_word,
    input  logic [15:0] rd_word,
    output logic [15:0] code,
    output logic [15:0] rd_eff
);
    localparam logic [15:0] WR_LIM = 16'(MAX_WR);
    localparam logic [15:0] RD_LIM = 16'(MAX_RD);

    logic duplex;

    always_comb begin
        duplex = (rd_word == RD_DUPLEX);
        rd_eff = duplex ? wr_word : rd_word;
        if (!bridge_en)                code = CODE_OFF;
        else if (wr_word > WR_LIM)     code = CODE_WR_LIMIT;
        else if (duplex && !duplex_ok) code = CODE_NO_DUPLEX;
        else if (rd_eff > RD_LIM)      code = CODE_RD_LIMIT;
        else                           code = CODE_OK;
    end
endmodule

// File: rtl/brx_wr_track.sv
// Counts the write bytes of a transfer and drives the buffer write port.
module brx_wr_track #(
    parameter int MAX_WR = 298,
    parameter int AW     = (MAX_WR > 1) ? $clog2(MAX_WR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [7:0]    din,
    output logic [15:0]   cnt,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [7:0]    data
);
    localparam int CW = $clog2(MAX_WR + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            we    <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else begin
            we <= inc;
            if (clr) cnt_q <= '0;
            else if (inc) cnt_q <= cnt_q + 1'b1;
            if (inc) begin
                addr <= cnt_q[AW-1:0];
                data <= din;
            end
        end
    end

    assign cnt = 16'(cnt_q);
endmodule

// File: rtl/brx_cmd_rx.sv
module brx_cmd_rx
    import brx_pkg::*;
#(
    parameter int MAX_WR = 298,
    parameter int MAX_RD = 298,
    localparam int AW    = (MAX_WR > 1) ? $clog2(MAX_WR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          in_last,
    input  logic          bridge_en,
    input  logic          duplex_ok,
    output logic          wbuf_we,
    output logic [AW-1:0] wbuf_addr,
    output logic [7:0]    wbuf_data,
    output logic [15:0]   wr_len,
    output logic [15:0]   rd_len,
    output logic [15:0]   status,
    output logic          xfer_go,
    output logic          cfg_req,
    output logic          rsp_req
);
    rx_state_e   state_q, nxt_state;
    hdr_kind_e   kind_q, nxt_kind;
    logic [1:0]  hpos_q, nxt_hpos;
    logic        busy_q, busy_d;
    logic [15:0] wr_pend_q, wr_len_q, rd_len_q, status_q;
    logic        go_q, cfg_q, rsp_q;

    logic [15:0] word, chk_code, rd_eff, rcvd, err_code;
    logic        lo_en, err, clr_stat, accept, go, cfg, replay;
    logic        trk_clr, trk_inc, take_wr;
    logic [15:0] rcvd_next;

    assign lo_en = in_valid &&
                   ((state_q == RX_ID_LO) || (state_q == RX_HEADER && !hpos_q[0]));

    brx_word_join #(.BW(8)) u_join (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_en   (lo_en),
        .byte_in (in_byte),
        .word    (word)
    );

    brx_hdr_check #(.MAX_WR(MAX_WR), .MAX_RD(MAX_RD)) u_check (
        .bridge_en (bridge_en),
        .duplex_ok (duplex_ok),
        .wr_word   (wr_pend_q),
        .rd_word   (word),
        .code      (chk_code),
        .rd_eff    (rd_eff)
    );

    brx_wr_track #(.MAX_WR(MAX_WR), .AW(AW)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (trk_clr),
        .inc   (trk_inc),
        .din   (in_byte),
        .cnt   (rcvd),
        .we    (wbuf_we),
        .addr  (wbuf_addr),
        .data  (wbuf_data)
    );

    assign rcvd_next = rcvd + 16'd1;

    // next state and per-byte decisions
    always_comb begin
        nxt_state = state_q;
        nxt_kind  = kind_q;
        nxt_hpos  = hpos_q;
        busy_d    = busy_q;
        err       = 1'b0;
        err_code  = CODE_OK;
        clr_stat  = 1'b0;
        accept    = 1'b0;
        go        = 1'b0;
        cfg       = 1'b0;
        replay    = 1'b0;
        trk_clr   = 1'b0;
        trk_inc   = 1'b0;
        take_wr   = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                RX_ID_LO: begin
                    if (in_last) begin
                        err      = 1'b1;
                        err_code = CODE_UNEXPECTED;
                    end else begin
                        nxt_state = RX_ID_HI;
                    end
                end
                RX_ID_HI: begin
                    nxt_state = in_last ? RX_ID_LO : RX_DISCARD;
                    if (word == PID_START) begin
                        clr_stat = 1'b1;
                        busy_d   = 1'b0;
                        if (in_last) begin
                            err      = 1'b1;
                            err_code = CODE_UNEXPECTED;
                        end else begin
                            nxt_state = RX_HEADER;
                            nxt_kind  = HK_START;
                            nxt_hpos  = 2'd0;
                        end
                    end else if (word == PID_MORE && busy_q) begin
                        if (in_last) begin
                            err      = 1'b1;
                            err_code = CODE_UNEXPECTED;
                        end else begin
                            nxt_state = RX_HEADER;
                            nxt_kind  = HK_MORE;
                            nxt_hpos  = 2'd0;
                        end
                    end else if (word == PID_CONFIG && !busy_q) begin
                        cfg = 1'b1;
                    end else if (word == PID_REPLAY && !busy_q) begin
                        replay = 1'b1;
                    end else begin
                        err      = 1'b1;
                        err_code = CODE_UNEXPECTED;
                    end
                end
                RX_HEADER: begin
                    nxt_hpos = hpos_q + 2'd1;
                    if (!hpos_q[0]) begin
                        if (in_last) begin
                            err      = 1'b1;
                            err_code = CODE_UNEXPECTED;
                        end
                    end else if (kind_q == HK_MORE) begin
                        if (word != rcvd) begin
                            err      = 1'b1;
                            err_code = CODE_BAD_INDEX;
                        end else if (in_last) begin
                            nxt_state = RX_ID_LO;
                            if (rcvd == wr_len_q) begin
                                go     = 1'b1;
                                busy_d = 1'b0;
                            end
                        end else begin
                            nxt_state = RX_PAYLOAD;
                        end
                    end else if (hpos_q == 2'd1) begin
                        take_wr = 1'b1;
                        if (in_last) begin
                            err      = 1'b1;
                            err_code = CODE_UNEXPECTED;
                        end
                    end else begin
                        if (chk_code != CODE_OK) begin
                            err      = 1'b1;
                            err_code = chk_code;
                        end else begin
                            accept  = 1'b1;
                            trk_clr = 1'b1;
                            busy_d  = 1'b1;
                            if (in_last) begin
                                nxt_state = RX_ID_LO;
                                if (wr_pend_q == '0) begin
                                    go     = 1'b1;
                                    busy_d = 1'b0;
                                end
                            end else begin
                                nxt_state = RX_PAYLOAD;
                            end
                        end
                    end
                end
                RX_PAYLOAD: begin
                    if (rcvd == wr_len_q) begin
                        err      = 1'b1;
                        err_code = CODE_OVERFLOW;
                    end else begin
                        trk_inc = 1'b1;
                        if (in_last) begin
                            nxt_state = RX_ID_LO;
                            if (rcvd_next == wr_len_q) begin
                                go     = 1'b1;
                                busy_d = 1'b0;
                            end
                        end
                    end
                end
                RX_DISCARD: begin
                    if (in_last) nxt_state = RX_ID_LO;
                end
                default: nxt_state = RX_ID_LO;
            endcase
            if (err) begin
                busy_d    = 1'b0;
                nxt_state = in_last ? RX_ID_LO : RX_DISCARD;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_ID_LO;
            kind_q  <= HK_START;
            hpos_q  <= 2'd0;
            busy_q  <= 1'b0;
        end else begin
            state_q <= nxt_state;
            kind_q  <= nxt_kind;
            hpos_q  <= nxt_hpos;
            busy_q  <= busy_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend_q <= '0;
            wr_len_q  <= '0;
            rd_len_q  <= '0;
            status_q  <= CODE_OK;
            go_q      <= 1'b0;
            cfg_q     <= 1'b0;
            rsp_q     <= 1'b0;
        end else begin
            go_q  <= go;
            cfg_q <= cfg;
            rsp_q <= err | replay;
            if (err)           status_q <= err_code;
            else if (clr_stat) status_q <= CODE_OK;
            if (take_wr) wr_pend_q <= word;
            if (accept) begin
                wr_len_q <= wr_pend_q;
                rd_len_q <= rd_eff;
            end
        end
    end

    assign wr_len  = wr_len_q;
    assign rd_len  = rd_len_q;
    assign status  = status_q;
    assign xfer_go = go_q;
    assign cfg_req = cfg_q;
    assign rsp_req = rsp_q;
endmodule

// File: rtl/brx_cmd_rx_chk.sv
module brx_cmd_rx_chk #(
    parameter int MAX_WR = 298,
    localparam int AW    = (MAX_WR > 1) ? $clog2(MAX_WR) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [15:0]   status,
    input logic          xfer_go,
    input logic          cfg_req,
    input logic          rsp_req,
    input logic          wbuf_we,
    input logic [AW-1:0] wbuf_addr,
    input logic [15:0]   wr_len
);
    // R12: the three request pulses never overlap
    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_go, cfg_req, rsp_req}));

    // R11: transfer start only with a clean status
    p_go_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> (status == 16'h0000));

    // R11: the start pulse lasts one cycle
    p_go_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> !xfer_go);

    // R12: a new fault code comes with a response request
    p_fault_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status) && status != 16'h0000) |-> rsp_req);

    // R5: no buffer write lands at or beyond the write length
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_we |-> (16'(wbuf_addr) < wr_len));

    // R13: a configuration query leaves the status alone
    p_cfg_status_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> $stable(status));
endmodule

bind brx_cmd_rx brx_cmd_rx_chk #(.MAX_WR(MAX_WR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status),
    .xfer_go   (xfer_go),
    .cfg_req   (cfg_req),
    .rsp_req   (rsp_req),
    .wbuf_we   (wbuf_we),
    .wbuf_addr (wbuf_addr),
    .wr_len    (wr_len)
);

// File: tb/tb_brx_cmd_rx.sv
module tb_brx_cmd_rx;
    localparam int MAXW = 20;
    localparam int MAXR = 16;
    localparam int AW   = $clog2(MAXW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          in_last = 1'b0;
    logic          bridge_en = 1'b1;
    logic          duplex_ok = 1'b1;
    logic          wbuf_we;
    logic [AW-1:0] wbuf_addr;
    logic [7:0]    wbuf_data;
    logic [15:0]   wr_len, rd_len, status;
    logic          xfer_go, cfg_req, rsp_req;

    brx_cmd_rx #(.MAX_WR(MAXW), .MAX_RD(MAXR)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .bridge_en(bridge_en), .duplex_ok(duplex_ok),
        .wbuf_we(wbuf_we), .wbuf_addr(wbuf_addr), .wbuf_data(wbuf_data),
        .wr_len(wr_len), .rd_len(rd_len), .status(status),
        .xfer_go(xfer_go), .cfg_req(cfg_req), .rsp_req(rsp_req)
    );

    always #2 clk = ~clk;

    int nvec = 0, nbad = 0;
    int go_n, cfg_n, rsp_n, wr_n;
    logic [7:0] mem [32];
    logic [7:0] pkt [64];
    int plen;
    bit finished = 0;

    // observe pulses and buffer writes away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_go) go_n++;
            if (cfg_req) cfg_n++;
            if (rsp_req) rsp_n++;
            if (wbuf_we) begin
                mem[wbuf_addr] = wbuf_data;
                wr_n++;
            end
        end
    end

    function automatic logic [7:0] dat(int i);
        return 8'(i * 37 + 11);
    endfunction

    task automatic check(string req, int act, int exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        go_n = 0; cfg_n = 0; rsp_n = 0; wr_n = 0;
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    endtask

    task automatic put16(int idx, int val);
        pkt[idx]   = 8'(val);
        pkt[idx+1] = 8'(val >> 8);
    endtask

    task automatic mk_start(int wr, int rd, int npay, int base);
        put16(0, 2); put16(2, wr); put16(4, rd);
        for (int k = 0; k < npay; k++) pkt[6+k] = dat(base + k);
        plen = 6 + npay;
    endtask

    task automatic mk_cont(int idx, int npay, int base);
        put16(0, 3); put16(2, idx);
        for (int k = 0; k < npay; k++) pkt[4+k] = dat(base + k);
        plen = 4 + npay;
    endtask

    task automatic send(bit gap);
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = pkt[i];
            in_last  = (i == plen - 1);
            if (gap) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        clear_obs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state (R10, R2)
        check("R10 reset status", int'(status), 0);
        check("R2 reset wr_len", int'(wr_len), 0);
        check("R2 reset rd_len", int'(rd_len), 0);
        check("R11 reset pulses", go_n + cfg_n + rsp_n + wr_n, 0);

        // sweep every write length, two packet splits, with and without gaps
        for (int wr = 0; wr <= MAXW; wr++) begin
            for (int sp = 0; sp < 2; sp++) begin
                int chunk, first, sent, rd, bad;
                chunk = sp ? 6 : 3;
                rd = (wr * 3) % (MAXR + 1);
                clear_obs();
                first = (wr < chunk) ? wr : chunk;
                mk_start(wr, rd, first, 0);
                send(bit'(wr % 2));
                sent = first;
                while (sent < wr) begin
                    int n;
                    n = (wr - sent < chunk) ? wr - sent : chunk;
                    mk_cont(sent, n, sent);
                    send(bit'(sp));
                    sent += n;
                end
                bad = 0;
                for (int i = 0; i < wr; i++) if (mem[i] !== dat(i)) bad++;
                check("R3 buffer contents", bad, 0);
                check("R3 write count", wr_n, wr);
                check("R11 go once", go_n, 1);
                check("R10 status ok", int'(status), 0);
                check("R2 wr_len", int'(wr_len), wr);
                check("R2 rd_len", int'(rd_len), rd);
                check("R12 no rsp", rsp_n, 0);
            end
        end

        // limits (R7)
        clear_obs(); mk_start(MAXW + 1, 0, 0, 0); send(0);
        check("R7 wr limit code", int'(status), 3);
        check("R12 rsp on wr limit", rsp_n, 1);
        check("R2 wr_len held", int'(wr_len), MAXW);
        check("R11 no go", go_n, 0);
        clear_obs(); mk_start(4, MAXR + 1, 4, 0); send(0);
        check("R7 rd limit code", int'(status), 4);
        check("R5 no write after header fault", wr_n, 0);

        // full duplex (R8)
        clear_obs(); mk_start(10, 16'hFFFF, 6, 0); send(0);
        mk_cont(6, 4, 6); send(1);
        check("R8 duplex rd_len", int'(rd_len), 10);
        check("R8 duplex go", go_n, 1);
        clear_obs(); mk_start(18, 16'hFFFF, 0, 0); send(0);
        check("R8 duplex length over read limit", int'(status), 4);
        duplex_ok = 1'b0;
        clear_obs(); mk_start(5, 16'hFFFF, 5, 0); send(0);
        check("R8 duplex unsupported", int'(status), 9);
        clear_obs(); mk_start(MAXW + 5, 16'hFFFF, 0, 0); send(0);
        check("R9 wr limit ranks above duplex", int'(status), 3);
        duplex_ok = 1'b1;

        // disabled bridge (R9)
        bridge_en = 1'b0;
        clear_obs(); mk_start(4, 2, 4, 0); send(0);
        check("R9 disabled code", int'(status), 5);
        check("R9 disabled no write", wr_n, 0);
        clear_obs(); mk_start(MAXW + 5, MAXR + 5, 0, 0); send(0);
        check("R9 disabled ranks first", int'(status), 5);
        bridge_en = 1'b1;

        // configuration query and replay while idle (R13)
        clear_obs(); put16(0, 0); plen = 2; send(0);
        check("R13 cfg pulse", cfg_n, 1);
        check("R13 cfg keeps status", int'(status), 5);
        clear_obs(); put16(0, 0); put16(2, 2); plen = 4; send(1);
        check("R13 cfg trailing bytes ignored", cfg_n + rsp_n + go_n, 1);
        check("R13 status after padded cfg", int'(status), 5);
        clear_obs(); put16(0, 4); plen = 2; send(0);
        check("R13 replay pulse", rsp_n, 1);
        check("R13 replay keeps status", int'(status), 5);

        // a new start clears the status (R10)
        clear_obs(); mk_start(2, 1, 2, 40); send(0);
        check("R10 status cleared", int'(status), 0);
        check("R11 go after clear", go_n, 1);
        check("R3 data after clear", int'(mem[1]), int'(dat(41)));

        // wrong continuation index (R4)
        clear_obs(); mk_start(10, 0, 4, 0); send(0);
        mk_cont(3, 6, 4); send(0);
        check("R4 bad index code", int'(status), 6);
        check("R12 rsp on bad index", rsp_n, 1);
        check("R4 no write from bad packet", wr_n, 4);
        clear_obs(); mk_cont(4, 6, 4); send(0);
        check("R6 continue after abort", int'(status), 8);
        check("R11 no go after abort", go_n, 0);

        // too much payload (R5)
        clear_obs(); mk_start(3, 0, 5, 0); send(0);
        check("R5 overflow code", int'(status), 7);
        check("R5 writes stop at count", wr_n, 3);
        check("R11 no go on overflow", go_n, 0);
        clear_obs(); mk_start(8, 0, 4, 0); send(0);
        mk_cont(4, 6, 4); send(1);
        check("R5 overflow in continue", int'(status), 7);
        check("R5 writes across packets", wr_n, 8);

        // unexpected packets (R6, R1)
        clear_obs(); mk_cont(0, 2, 0); send(0);
        check("R6 continue while idle", int'(status), 8);
        mk_start(0, 0, 0, 0); send(0);
        clear_obs(); put16(0, 7); plen = 2; send(0);
        check("R6 unknown id", int'(status), 8);
        mk_start(0, 0, 0, 0); send(0);
        clear_obs(); put16(0, 16'h0102); put16(2, 4); put16(4, 0); plen = 6; send(0);
        check("R1 high id byte decoded", int'(status), 8);
        check("R1 no go for wide id", go_n, 0);
        clear_obs(); mk_start(10, 0, 4, 0); send(0);
        put16(0, 0); plen = 2; send(0);
        check("R6 cfg while busy", int'(status), 8);
        check("R6 no cfg pulse while busy", cfg_n, 0);
        clear_obs(); mk_start(10, 0, 0, 0); plen = 3; send(0);
        check("R6 truncated header", int'(status), 8);
        mk_start(0, 0, 0, 0); send(0);
        clear_obs(); pkt[0] = 8'h02; plen = 1; send(0);
        check("R6 one byte packet", int'(status), 8);
        check("R12 rsp on short packet", rsp_n, 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule